// File: doc/BRIEF.md
# Infrared SIR Serial Transceiver

This block is a byte-wide asynchronous serial transceiver whose line is an infrared pulse channel rather than a plain UART wire. Software writes a byte into a single-entry transmit buffer. The shifter sends it as a ten-cell frame: one start cell, eight data cells with the least significant bit first, and one stop cell. Each cell lasts 16 ticks of an externally supplied oversampling strobe. A zero cell carries a high pulse at its start and a one cell carries none. The pulse is either a short fixed width or a three-tick width, chosen by a control bit.

The receive side synchronises the incoming pulse line and restarts its cell timing on the first pulse edge. It classifies each cell by whether a pulse edge fell inside it, and hands the assembled byte to a one-entry receive buffer. A separate checker measures every received pulse in ticks and latches an error when the width is out of range. Sticky error flags, interrupt masking and a single interrupt line complete the block. Registers are 16 bits wide and are addressed by a 3-bit word index.

Register map by word index: 0 control, 1 status, 2 interrupt mask, 3 transmit data, 4 receive data, 5 infrared control, 6 infrared status, 7 error mirror.

Top module: `irsir_xcvr`

## Requirements
- R1: After reset, status (index 1) reads 0x0003, with transmit-buffer-empty in bit 0 and shift-register-empty in bit 1. irq and ir_tx are 0.
- R2: Once control (index 0) bit 0 enables transmit, a buffered byte is sent as ten 16-tick cells in this order: start, data bits 0 to 7, stop. A zero cell begins with a pulse and a one cell carries no pulse.
- R3: When infrared control (index 5) bit 1 is clear, each transmit pulse lasts 1 tick. When that bit is set, each pulse lasts 3 ticks.
- R4: A write to transmit data (index 3) clears status bit 0. Status bit 0 returns to 1 when the shifter takes the byte. Status bit 1 is 0 while a frame is being shifted out.
- R5: Writing 1 to control bit 2 empties the transmit buffer, which sets status bit 0. A byte that is discarded this way is never sent.
- R6: A received frame sets status bit 2 (receive buffer full). Receive data (index 4) then returns the byte in bits 7:0.
- R7: While control bit 1 is clear, received pulses start no frame and status bit 2 stays 0.
- R8: A frame that completes while status bit 2 is still set raises overrun (bit 5) and the sum flag (bit 6). The byte already buffered is kept.
- R9: A pulse inside the stop cell raises framing error (bit 4) and sum (bit 6). The byte is still delivered.
- R10: A read of receive data clears status bits 2 to 6.
- R11: Error mirror (index 7) shows the sum, overrun, framing and parity flags in bits 6 to 3. Any write to it clears all of them.
- R12: Infrared status (index 6) bit 0 latches when a received pulse lasts less than 1 tick or more than 8 ticks. Pulses of 1 to 8 ticks leave it at 0. Writing 1 to infrared control bit 0 clears it.
- R13: irq is the OR of four terms, each a flag ANDed with its mask bit (index 2): sum (bit 6), receive full (bit 2), shift empty (bit 1) and buffer empty (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ir_rx | input | 1 | Incoming infrared pulse line |
| ir_tx | output | 1 | Outgoing infrared pulse line |
| irq | output | 1 | Interrupt request |

## Verification
The overrun is the hardest state to reach from the ports. It needs a second frame to finish while the first byte is still unread. The stimulus loops ir_tx back to ir_rx and refills the transmit buffer as soon as the first byte is taken, so two frames run back to back with no read in between. The framing and pulse-width errors cannot come from the transmitter at all. The bench therefore drives ir_rx directly: it sends a hand-built frame with a stop-cell pulse, pulses of 8 and 10 ticks, and a one-cycle glitch that falls between two ticks.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RS_CTRL   = 3'd0,
        RS_STAT   = 3'd1,
        RS_IMSK   = 3'd2,
        RS_TXD    = 3'd3,
        RS_RXD    = 3'd4,
        RS_IRCTL  = 3'd5,
        RS_IRSTAT = 3'd6,
        RS_ERRMIR = 3'd7
    } reg_sel_e;

    // status / mask bit positions
    localparam int ST_SUM = 6;
    localparam int ST_OVR = 5;
    localparam int ST_FRM = 4;
    localparam int ST_PAR = 3;
    localparam int ST_RBF = 2;
    localparam int ST_TSE = 1;
    localparam int ST_TBE = 0;

    // control bit positions
    localparam int CT_TCLR = 2;
    localparam int CT_REN  = 1;
    localparam int CT_TEN  = 0;

    // infrared control bit positions
    localparam int IC_PSEL = 1;
    localparam int IC_ECLR = 0;

    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
    } rx_err_t;

    typedef struct packed {
        logic sum;
        logic rbf;
        logic tse;
        logic tbe;
    } irq_src_t;

    function automatic logic [REG_W-1:0] err_word(input rx_err_t e);
        logic [REG_W-1:0] w;
        w         = '0;
        w[ST_SUM] = e.ovr | e.frm | e.par;
        w[ST_OVR] = e.ovr;
        w[ST_FRM] = e.frm;
        w[ST_PAR] = e.par;
        return w;
    endfunction

endpackage

// File: rtl/irsir_tx.sv
module irsir_tx #(
    parameter int DATA_W   = 8,
    parameter int OVS      = 16,
    parameter int PW_LONG  = 3,
    parameter int PW_SHORT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              long_pw,
    output logic              take,
    output logic              busy,
    output logic              ir_out
);
    localparam int FW = DATA_W + 2;
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(FW);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(FW - 1);
    localparam logic [SW-1:0] W_LONG   = SW'(PW_LONG);
    localparam logic [SW-1:0] W_SHORT  = SW'(PW_SHORT);

    logic [FW-1:0] shreg;
    logic [SW-1:0] sub;
    logic [BW-1:0] bidx;
    logic          busy_q;
    logic          last_tick;
    logic [SW-1:0] pw_lim;

    assign last_tick = busy_q && (sub == SUB_LAST) && (bidx == BIT_LAST);
    assign take      = tick && en && buf_full && (!busy_q || last_tick);
    assign pw_lim    = long_pw ? W_LONG : W_SHORT;
    assign busy      = busy_q;
    assign ir_out    = busy_q && !shreg[0] && (sub < pw_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '1;
            sub    <= '0;
            bidx   <= '0;
            busy_q <= 1'b0;
        end else if (tick) begin
            if (take) begin
                shreg  <= {1'b1, buf_data, 1'b0};
                sub    <= '0;
                bidx   <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (sub == SUB_LAST) begin
                    sub <= '0;
                    if (bidx == BIT_LAST) begin
                        busy_q <= 1'b0;
                        bidx   <= '0;
                    end else begin
                        bidx  <= bidx + 1'b1;
                        shreg <= {1'b1, shreg[FW-1:1]};
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end

    // R2
    tx_frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(bidx) == BIT_LAST));

endmodule

// File: rtl/irsir_rx.sv
module irsir_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              rise,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              frm_err
);
    localparam int SW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W + 2);
    localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
    localparam logic [BW-1:0] BIT_STOP = BW'(DATA_W + 1);
    localparam logic [BW-1:0] BIT_MSB  = BW'(DATA_W);

    logic              active;
    logic [SW-1:0]     sub;
    logic [BW-1:0]     bidx;
    logic              seen;
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sub     <= '0;
            bidx    <= '0;
            seen    <= 1'b0;
            sh      <= '0;
            done    <= 1'b0;
            data    <= '0;
            frm_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (en && rise) begin
                    active <= 1'b1;
                    sub    <= '0;
                    bidx   <= '0;
                    seen   <= 1'b1;
                end
            end else if (tick && (sub == SUB_LAST)) begin
                sub  <= '0;
                seen <= rise;
                if (bidx == BIT_STOP) begin
                    done    <= 1'b1;
                    frm_err <= seen;
                    data    <= sh;
                    active  <= 1'b0;
                    bidx    <= '0;
                end else begin
                    if ((bidx != '0) && (bidx <= BIT_MSB))
                        sh <= {!seen, sh[DATA_W-1:1]};
                    bidx <= bidx + 1'b1;
                end
            end else begin
                if (tick) sub <= sub + 1'b1;
                if (rise) seen <= 1'b1;
            end
        end
    end

    // R7
    rx_start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(en));

endmodule

// File: rtl/irsir_pwchk.sv
module irsir_pwchk #(
    parameter int PW_MIN = 1,
    parameter int PW_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level,
    input  logic fall,
    output logic bad
);
    localparam int CW = $clog2(PW_MAX + 2);
    localparam logic [CW-1:0] MINV = CW'(PW_MIN);
    localparam logic [CW-1:0] MAXV = CW'(PW_MAX);
    localparam logic [CW-1:0] SATV = CW'(PW_MAX + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            bad <= 1'b0;
        end else begin
            bad <= 1'b0;
            if (fall) begin
                bad <= (cnt < MINV) || (cnt > MAXV);
                cnt <= '0;
            end else if (level && tick && (cnt != SATV)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/irsir_xcvr.sv
module irsir_xcvr
    import irsir_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int PW_LONG     = 3,
    parameter int PW_SHORT    = 1,
    parameter int PW_MIN      = 1,
    parameter int PW_MAX      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ir_rx,
    output logic              ir_tx,
    output logic              irq
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    logic wr_ctrl, wr_imsk, wr_txd, wr_irctl, wr_errmir, rd_rxd;
    assign wr_ctrl   = bus_wr && (sel == RS_CTRL);
    assign wr_imsk   = bus_wr && (sel == RS_IMSK);
    assign wr_txd    = bus_wr && (sel == RS_TXD);
    assign wr_irctl  = bus_wr && (sel == RS_IRCTL);
    assign wr_errmir = bus_wr && (sel == RS_ERRMIR);
    assign rd_rxd    = bus_rd && (sel == RS_RXD);

    logic unused_wd;
    assign unused_wd = ^{bus_wdata[REG_W-1:8], bus_wdata[5:3]};

    // control and configuration state
    logic              ten, ren, psel;
    irq_src_t          imsk;
    logic [DATA_W-1:0] tbuf;
    logic              tfull;
    logic [DATA_W-1:0] rx_hold;
    logic              rbf;
    rx_err_t           err;
    logic              perr;

    // receive line synchroniser
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_lvl, rx_prev, rx_rise, rx_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            rx_prev <= 1'b0;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], ir_rx};
            rx_prev <= rx_lvl;
        end
    end
    assign rx_lvl  = sync_q[SYNC_STAGES-1];
    assign rx_rise = rx_lvl && !rx_prev;
    assign rx_fall = !rx_lvl && rx_prev;

    // sub-blocks
    logic              tx_take, tx_busy;
    logic              rx_done, rx_frm;
    logic [DATA_W-1:0] rx_data;
    logic              pw_bad;

    irsir_tx #(
        .DATA_W(DATA_W), .OVS(OVS), .PW_LONG(PW_LONG), .PW_SHORT(PW_SHORT)
    ) u_tx (
        .clk(clk), .rst(rst), .tick(tick16), .en(ten),
        .buf_full(tfull), .buf_data(tbuf), .long_pw(psel),
        .take(tx_take), .busy(tx_busy), .ir_out(ir_tx)
    );

    irsir_rx #(
        .DATA_W(DATA_W), .OVS(OVS)
    ) u_rx (
        .clk(clk), .rst(rst), .tick(tick16), .en(ren), .rise(rx_rise),
        .done(rx_done), .data(rx_data), .frm_err(rx_frm)
    );

    irsir_pwchk #(
        .PW_MIN(PW_MIN), .PW_MAX(PW_MAX)
    ) u_pw (
        .clk(clk), .rst(rst), .tick(tick16), .level(rx_lvl),
        .fall(rx_fall), .bad(pw_bad)
    );

    // register state
    always_ff @(posedge clk) begin
        if (rst) begin
            ten     <= 1'b0;
            ren     <= 1'b0;
            psel    <= 1'b0;
            imsk    <= '0;
            tbuf    <= '0;
            tfull   <= 1'b0;
            rx_hold <= '0;
            rbf     <= 1'b0;
            err     <= '0;
            perr    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ten <= bus_wdata[CT_TEN];
                ren <= bus_wdata[CT_REN];
            end
            if (wr_imsk) begin
                imsk.sum <= bus_wdata[ST_SUM];
                imsk.rbf <= bus_wdata[ST_RBF];
                imsk.tse <= bus_wdata[ST_TSE];
                imsk.tbe <= bus_wdata[ST_TBE];
            end
            if (wr_irctl) psel <= bus_wdata[IC_PSEL];

            // transmit buffer
            if (tx_take) tfull <= 1'b0;
            if (wr_txd) begin
                tbuf  <= bus_wdata[DATA_W-1:0];
                tfull <= 1'b1;
            end
            if (wr_ctrl && bus_wdata[CT_TCLR]) tfull <= 1'b0;

            // receive buffer and sticky errors
            if (rd_rxd) rbf <= 1'b0;
            if (rd_rxd || wr_errmir) err <= '0;
            if (rx_done) begin
                if (rbf && !rd_rxd) begin
                    err.ovr <= 1'b1;
                end else begin
                    rx_hold <= rx_data;
                    rbf     <= 1'b1;
                end
                if (rx_frm) err.frm <= 1'b1;
            end

            // pulse width error
            if (pw_bad) perr <= 1'b1;
            else if (wr_irctl && bus_wdata[IC_ECLR]) perr <= 1'b0;
        end
    end

    logic sum_f, tse_f, tbe_f;
    assign sum_f = err.ovr | err.frm | err.par;
    assign tse_f = !tx_busy;
    assign tbe_f = !tfull;

    assign irq = (imsk.sum & sum_f) | (imsk.rbf & rbf) |
                 (imsk.tse & tse_f) | (imsk.tbe & tbe_f);

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RS_CTRL: begin
                bus_rdata[CT_REN] = ren;
                bus_rdata[CT_TEN] = ten;
            end
            RS_STAT: begin
                bus_rdata         = err_word(err);
                bus_rdata[ST_RBF] = rbf;
                bus_rdata[ST_TSE] = tse_f;
                bus_rdata[ST_TBE] = tbe_f;
            end
            RS_IMSK: begin
                bus_rdata[ST_SUM] = imsk.sum;
                bus_rdata[ST_RBF] = imsk.rbf;
                bus_rdata[ST_TSE] = imsk.tse;
                bus_rdata[ST_TBE] = imsk.tbe;
            end
            RS_RXD:    bus_rdata[DATA_W-1:0] = rx_hold;
            RS_IRCTL:  bus_rdata[IC_PSEL] = psel;
            RS_IRSTAT: bus_rdata[0] = perr;
            RS_ERRMIR: bus_rdata = err_word(err);
            default:   bus_rdata = '0;
        endcase
    end

    // R4
    tx_start_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(tfull));

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rxd && !rx_done) |=> (!rbf && !sum_f));

    // R8
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rbf && !rd_rxd) |=> ($stable(rx_hold) && err.ovr));

    // R6
    rbf_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rbf) |-> $past(rx_done));

    // R12
    perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (perr && !(wr_irctl && bus_wdata[IC_ECLR])) |=> perr);

endmodule

// File: tb/sim_irsir_xcvr.sv
module sim_irsir_xcvr;

    localparam int TICKP = 4;
    localparam int CELL  = 16 * TICKP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick16 = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ir_rx;
    logic        ir_tx;
    logic        irq;
    logic        loop_en = 1'b0;
    logic        man_rx = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit done_flag = 0;

    typedef struct {
        logic [7:0] b;
        int         w;
    } txexp_t;
    txexp_t txq[$];

    assign ir_rx = loop_en ? ir_tx : man_rx;

    irsir_xcvr u0 (
        .clk(clk), .rst(rst), .tick16(tick16),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ir_rx(ir_rx), .ir_tx(ir_tx), .irq(irq)
    );

    always #5 clk = ~clk;

    initial begin : tickgen
        int tc;
        tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc == TICKP - 1) ? 0 : tc + 1;
            tick16 = (tc == 0);
        end
    end

    task automatic check_int(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] e);
        logic [15:0] d;
        reg_rd(a, d);
        check_int(req, int'(d), int'(e));
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (tick16 !== 1'b1);
        #1;
    endtask

    // wait for a frame (or back-to-back frames) to leave the shifter
    task automatic wait_tx_done();
        logic [15:0] d;
        int n;
        n = 0;
        do begin reg_rd(3'd1, d); n++; end while (d[1] == 1'b1 && n < 200);
        n = 0;
        do begin reg_rd(3'd1, d); n++; end while (d[1] == 1'b0 && n < 4000);
        repeat (8) @(negedge clk);
    endtask

    task automatic send_tx(input logic [7:0] b, input int w);
        txq.push_back('{b: b, w: w});
        reg_wr(3'd3, {8'h00, b});
    endtask

    task automatic send_manual(input logic [7:0] b, input bit stop_pulse);
        for (int c = 0; c < 10; c++) begin
            logic z;
            z = (c == 0) ? 1'b1 : (c == 9) ? stop_pulse : !b[c-1];
            wait_tick();
            man_rx = z;
            wait_tick();
            man_rx = 1'b0;
            repeat (14) wait_tick();
        end
        repeat (4) wait_tick();
    endtask

    task automatic pulse_ticks(input int n);
        wait_tick();
        man_rx = 1'b1;
        repeat (n) wait_tick();
        man_rx = 1'b0;
        repeat (4) wait_tick();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    // monitor: decode ir_tx frames and compare with the scoreboard queue
    initial begin : monitor
        int w, el;
        logic [7:0] got;
        bit stop_one;
        txexp_t e;
        forever begin
            @(negedge clk);
            if (ir_tx === 1'b1) begin
                if (txq.size() == 0) begin
                    nchk++; nerr++;
                    $display("FAIL R5: actual unexpected frame expected none");
                    e = '{b: 8'h00, w: 1};
                end else begin
                    e = txq.pop_front();
                end
                w = 0;
                while (ir_tx === 1'b1) begin w++; @(negedge clk); end
                el = w;
                check_int("R3 pulse width", w, e.w * TICKP);
                got = 8'h00;
                stop_one = 0;
                for (int c = 1; c <= 9; c++) begin
                    repeat (c * CELL - el) @(negedge clk);
                    el = c * CELL;
                    if (c <= 8) got[c-1] = (ir_tx !== 1'b1);
                    else stop_one = (ir_tx !== 1'b1);
                end
                check_int("R2 frame data", int'(got), int'(e.b));
                check_int("R2 stop cell", int'(stop_one), 1);
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [15:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk_reg("R1 status", 3'd1, 16'h0003);
        check_int("R1 irq", int'(irq), 0);
        check_int("R1 ir_tx", int'(ir_tx), 0);

        // R13 buffer-empty source
        reg_wr(3'd2, 16'h0001);
        @(negedge clk);
        check_int("R13 irq tbe", int'(irq), 1);
        reg_wr(3'd2, 16'h0000);
        @(negedge clk);
        check_int("R13 irq masked", int'(irq), 0);

        // R5 discard buffered byte, nothing sent
        reg_wr(3'd3, 16'h005A);
        chk_reg("R4 tbe clear after write", 3'd1, 16'h0002);
        reg_wr(3'd0, 16'h0004);
        chk_reg("R5 buffer emptied", 3'd1, 16'h0003);
        reg_wr(3'd0, 16'h0001);
        repeat (3 * CELL) @(negedge clk);
        chk_reg("R5 shifter idle", 3'd1, 16'h0003);

        // R2 R3 R4 R6 short pulse loopback
        loop_en = 1'b1;
        reg_wr(3'd0, 16'h0000);
        send_tx(8'hA5, 1);
        chk_reg("R4 waiting byte", 3'd1, 16'h0002);
        reg_wr(3'd0, 16'h0003);
        repeat (20) @(negedge clk);
        chk_reg("R4 shifting", 3'd1, 16'h0001);
        wait_tx_done();
        chk_reg("R6 rbf set", 3'd1, 16'h0007);
        chk_reg("R6 rx data", 3'd4, 16'h00A5);
        chk_reg("R10 cleared after read", 3'd1, 16'h0003);

        // R3 long pulse
        reg_wr(3'd5, 16'h0002);
        send_tx(8'h3C, 3);
        wait_tx_done();
        chk_reg("R6 rx data long", 3'd4, 16'h003C);
        chk_reg("R12 no width error", 3'd6, 16'h0000);
        reg_wr(3'd5, 16'h0000);

        // R8 overrun via back-to-back frames
        send_tx(8'h0F, 1);
        begin
            int n;
            n = 0;
            do begin reg_rd(3'd1, d); n++; end while (d[0] == 1'b0 && n < 500);
        end
        send_tx(8'hF0, 1);
        wait_tx_done();
        chk_reg("R8 overrun status", 3'd1, 16'h0067);
        chk_reg("R11 mirror", 3'd7, 16'h0060);
        reg_wr(3'd2, 16'h0040);
        @(negedge clk);
        check_int("R13 irq sum", int'(irq), 1);
        reg_wr(3'd7, 16'h0000);
        @(negedge clk);
        check_int("R13 irq after clear", int'(irq), 0);
        chk_reg("R11 cleared", 3'd1, 16'h0007);
        reg_wr(3'd2, 16'h0004);
        @(negedge clk);
        check_int("R13 irq rbf", int'(irq), 1);
        reg_wr(3'd2, 16'h0000);
        chk_reg("R8 first byte kept", 3'd4, 16'h000F);

        // R9 framing error from a hand-built frame
        loop_en = 1'b0;
        reg_wr(3'd0, 16'h0002);
        send_manual(8'h81, 1'b1);
        chk_reg("R9 framing status", 3'd1, 16'h0057);
        chk_reg("R9 data delivered", 3'd4, 16'h0081);
        chk_reg("R10 errors cleared", 3'd1, 16'h0003);

        // R6 hand-built good frame
        send_manual(8'h6B, 1'b0);
        chk_reg("R6 manual rbf", 3'd1, 16'h0007);
        chk_reg("R6 manual data", 3'd4, 16'h006B);

        // R7 receiver disabled
        reg_wr(3'd0, 16'h0000);
        send_manual(8'h00, 1'b0);
        chk_reg("R7 no receive", 3'd1, 16'h0003);

        // R12 pulse width checks
        chk_reg("R12 clean", 3'd6, 16'h0000);
        pulse_ticks(8);
        chk_reg("R12 eight ticks ok", 3'd6, 16'h0000);
        pulse_ticks(10);
        chk_reg("R12 long pulse", 3'd6, 16'h0001);
        reg_wr(3'd5, 16'h0001);
        chk_reg("R12 cleared", 3'd6, 16'h0000);
        wait_tick();
        man_rx = 1'b1;
        @(posedge clk); #1;
        man_rx = 1'b0;
        repeat (4) wait_tick();
        chk_reg("R12 glitch", 3'd6, 16'h0001);

        check_int("R2 scoreboard drained", txq.size(), 0);
        finish_run();
    end

endmodule